// File: doc/BRIEF.md
# Inbound Stream Channel Controller

This block is the control and status engine for a single inbound sample channel. Software programs one 32-bit control/status word to choose a stream number, start or stop the channel, and enable interrupts. An inbound sample bus carries a 4-bit tag with each sample. While the channel is running, a sample is captured into a small FIFO only when its tag equals the programmed stream number. A downstream consumer drains the FIFO through a valid/ready port.

Pulses from the descriptor side report three events: a descriptor has been loaded, a descriptor fetch has failed, or the last sample of a buffer has been processed (together with that buffer's interrupt-on-completion flag). These events set sticky status bits, which software clears by writing 1 to them. A fetch failure is fatal and stops the channel in hardware. A sample that reaches a full FIFO is dropped and raises an error flag. One interrupt line combines each status bit with its own enable.

Top module: `instream_ctl`

## Requirements
- R1: After reset the word reads 0x00040000. Bit 18 always reads 1. Bits 31:30, 25:24, 19, 17:16 and 15:5 always read 0, whatever software writes.
- R2: Control fields are written by every register write and read back as written: bit 0 stream reset, bit 1 RUN, bit 2 completion interrupt enable, bit 3 FIFO error interrupt enable, bit 4 descriptor error interrupt enable, bits 23:20 stream number.
- R3: A sample is captured only when RUN is 1, the stream number is nonzero, and the sample's tag equals the stream number. Captured samples leave the output port in arrival order. A stream number of 0 captures nothing.
- R4: A sample that is eligible for capture while the FIFO holds DEPTH entries is dropped. Bit 27 (FIFO error) is then set, whatever its enable. The contents already queued are delivered unchanged.
- R5: Bit 26 (buffer completion) is set when the last-sample pulse arrives with the interrupt-on-completion flag high. It is not set when the flag is low.
- R6: A descriptor fetch error pulse sets bit 28 and clears RUN on the same clock edge. This holds even when the same cycle's register write sets RUN.
- R7: Bits 26, 27 and 28 are cleared by writing 1 to them. Writing 0 to them leaves them unchanged.
- R8: If a hardware set event and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R9: Bit 29 (FIFO ready) is set by the descriptor-loaded pulse and is read-only.
- R10: While stream reset (bit 0) is 1, RUN and bits 26 to 29 read 0. The FIFO is emptied one cycle after stream reset is registered.
- R11: irq is high exactly when (bit 26 and bit 2) or (bit 27 and bit 3) or (bit 28 and bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_data | input | 32 | Register write data |
| csr_rd_data | output | 32 | Current register value |
| smp_valid | input | 1 | Inbound sample present |
| smp_tag | input | 4 | Stream tag of the inbound sample |
| smp_data | input | DW | Inbound sample payload |
| evt_desc_loaded | input | 1 | Descriptor loaded pulse |
| evt_desc_err | input | 1 | Descriptor fetch error pulse |
| evt_buf_last | input | 1 | Last sample of a buffer processed |
| evt_buf_ioc | input | 1 | Interrupt-on-completion flag of that buffer |
| out_valid | output | 1 | FIFO has a sample for the consumer |
| out_data | output | DW | Oldest captured sample |
| out_ready | input | 1 | Consumer accepts the sample |
| irq | output | 1 | Interrupt request |

## Verification
Capture is exercised with four input patterns: samples carrying a matching tag, samples carrying a foreign tag, samples sent while RUN is 0, and samples sent with a stream number of 0. Only the first pattern may reach the output. A scoreboard checks the order of the samples that do come out. A burst of one more sample than the FIFO depth, sent with the consumer stalled, separates a dropped sample from a corrupted queue.

The status logic is tested with these cases:
- The completion pulse with its flag low and with its flag high.
- A write-one-to-clear in the same cycle as the matching set event.
- A fetch error in the same cycle as a write that starts RUN.
- Writing 0 to each status bit, and then writing 1.

The interrupt line is checked with its enables both set and cleared.

// File: rtl/instream_pkg.sv
package instream_pkg;
    localparam int CSR_W     = 32;
    localparam int B_SRST    = 0;
    localparam int B_RUN     = 1;
    localparam int B_IOC_EN  = 2;
    localparam int B_FERR_EN = 3;
    localparam int B_DERR_EN = 4;
    localparam int B_PRIO    = 18;
    localparam int B_NUM_LO  = 20;
    localparam int NUM_W     = 4;
    localparam int B_BCIS    = 26;
    localparam int B_FERR    = 27;
    localparam int B_DERR    = 28;
    localparam int B_RDY     = 29;

    typedef struct packed {
        logic             srst;
        logic             run;
        logic             ioc_en;
        logic             ferr_en;
        logic             derr_en;
        logic [NUM_W-1:0] num;
        logic             bcis;
        logic             ferr;
        logic             derr;
        logic             rdy;
    } csr_state_t;
endpackage

// File: rtl/instream_csr.sv
module instream_csr
    import instream_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             desc_loaded,
    input  logic             desc_err,
    input  logic             buf_done,
    input  logic             overrun,
    output logic [CSR_W-1:0] rd_data,
    output logic             run,
    output logic             srst,
    output logic [NUM_W-1:0] num,
    output logic             irq
);
    csr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.srst    = wr_data[B_SRST];
            st_d.run     = wr_data[B_RUN];
            st_d.ioc_en  = wr_data[B_IOC_EN];
            st_d.ferr_en = wr_data[B_FERR_EN];
            st_d.derr_en = wr_data[B_DERR_EN];
            st_d.num     = wr_data[B_NUM_LO +: NUM_W];
            if (wr_data[B_BCIS]) st_d.bcis = 1'b0;
            if (wr_data[B_FERR]) st_d.ferr = 1'b0;
            if (wr_data[B_DERR]) st_d.derr = 1'b0;
        end
        // hardware set events take priority over software clears
        if (buf_done)    st_d.bcis = 1'b1;
        if (overrun)     st_d.ferr = 1'b1;
        if (desc_loaded) st_d.rdy  = 1'b1;
        if (desc_err) begin
            st_d.derr = 1'b1;
            st_d.run  = 1'b0;
        end
        if (st_d.srst) begin
            st_d.run  = 1'b0;
            st_d.bcis = 1'b0;
            st_d.ferr = 1'b0;
            st_d.derr = 1'b0;
            st_d.rdy  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[B_SRST]            = st_q.srst;
        rd_data[B_RUN]             = st_q.run;
        rd_data[B_IOC_EN]          = st_q.ioc_en;
        rd_data[B_FERR_EN]         = st_q.ferr_en;
        rd_data[B_DERR_EN]         = st_q.derr_en;
        rd_data[B_PRIO]            = 1'b1;
        rd_data[B_NUM_LO +: NUM_W] = st_q.num;
        rd_data[B_BCIS]            = st_q.bcis;
        rd_data[B_FERR]            = st_q.ferr;
        rd_data[B_DERR]            = st_q.derr;
        rd_data[B_RDY]             = st_q.rdy;
    end

    assign run  = st_q.run;
    assign srst = st_q.srst;
    assign num  = st_q.num;
    assign irq  = (st_q.bcis & st_q.ioc_en) | (st_q.ferr & st_q.ferr_en) |
                  (st_q.derr & st_q.derr_en);
endmodule

// File: rtl/instream_fifo.sv
module instream_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    output logic          full,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    input  logic          rd_ready,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t fs_d, fs_q;
    logic [DW-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    assign full     = (fs_q.cnt == CW'(DEPTH));
    assign rd_valid = (fs_q.cnt != '0);
    assign rd_data  = mem[fs_q.rd_ptr];
    assign count    = fs_q.cnt;
    assign do_wr    = wr_req && !full && !flush;
    assign do_rd    = rd_valid && rd_ready && !flush;

    always_comb begin
        fs_d = fs_q;
        if (flush) begin
            fs_d = '0;
        end else begin
            if (do_wr) fs_d.wr_ptr = (fs_q.wr_ptr == LAST) ? '0 : fs_q.wr_ptr + 1'b1;
            if (do_rd) fs_d.rd_ptr = (fs_q.rd_ptr == LAST) ? '0 : fs_q.rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   fs_d.cnt = fs_q.cnt + 1'b1;
                2'b01:   fs_d.cnt = fs_q.cnt - 1'b1;
                default: fs_d.cnt = fs_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[fs_q.wr_ptr] <= wr_data;
    end
endmodule

// File: rtl/instream_ctl.sv
module instream_ctl
    import instream_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr_en,
    input  logic [CSR_W-1:0] csr_wr_data,
    output logic [CSR_W-1:0] csr_rd_data,
    input  logic             smp_valid,
    input  logic [NUM_W-1:0] smp_tag,
    input  logic [DW-1:0]    smp_data,
    input  logic             evt_desc_loaded,
    input  logic             evt_desc_err,
    input  logic             evt_buf_last,
    input  logic             evt_buf_ioc,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    input  logic             out_ready,
    output logic             irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             run, srst, full, accept, overrun;
    logic [NUM_W-1:0] num;
    logic [CW-1:0]    fifo_count;

    assign accept  = smp_valid && run && (num != '0) && (smp_tag == num);
    assign overrun = accept && full;

    instream_csr u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (csr_wr_en),
        .wr_data     (csr_wr_data),
        .desc_loaded (evt_desc_loaded),
        .desc_err    (evt_desc_err),
        .buf_done    (evt_buf_last && evt_buf_ioc),
        .overrun     (overrun),
        .rd_data     (csr_rd_data),
        .run         (run),
        .srst        (srst),
        .num         (num),
        .irq         (irq)
    );

    instream_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (srst),
        .wr_req   (accept),
        .wr_data  (smp_data),
        .full     (full),
        .rd_valid (out_valid),
        .rd_data  (out_data),
        .rd_ready (out_ready),
        .count    (fifo_count)
    );
endmodule

// File: rtl/instream_ctl_chk.sv
module instream_ctl_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          csr_wr_en,
    input logic [31:0]   csr_wr_data,
    input logic [31:0]   csr_rd_data,
    input logic          evt_desc_err,
    input logic          evt_buf_last,
    input logic          evt_buf_ioc,
    input logic          overrun,
    input logic [CW-1:0] fifo_count
);
    logic srst_next;
    assign srst_next = csr_wr_en ? csr_wr_data[0] : csr_rd_data[0];

    assert_derr_fatal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_desc_err && !srst_next |=> csr_rd_data[28] && !csr_rd_data[1]);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_buf_last && evt_buf_ioc && !srst_next |=> csr_rd_data[26]);

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !srst_next |=> csr_rd_data[27] && (fifo_count <= $past(fifo_count)));

    assert_unused_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd_data[23:20] == 4'd0 |=> fifo_count <= $past(fifo_count));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        csr_wr_en && csr_wr_data[28] && !evt_desc_err |=> !csr_rd_data[28]);
endmodule

bind instream_ctl instream_ctl_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_wr_en    (csr_wr_en),
    .csr_wr_data  (csr_wr_data),
    .csr_rd_data  (csr_rd_data),
    .evt_desc_err (evt_desc_err),
    .evt_buf_last (evt_buf_last),
    .evt_buf_ioc  (evt_buf_ioc),
    .overrun      (overrun),
    .fifo_count   (fifo_count)
);

// File: tb/instream_ctl_bench.sv
module instream_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          csr_wr_en = 1'b0;
    logic [31:0]   csr_wr_data = '0;
    logic [31:0]   csr_rd_data;
    logic          smp_valid = 1'b0;
    logic [3:0]    smp_tag = '0;
    logic [DW-1:0] smp_data = '0;
    logic          evt_desc_loaded = 1'b0, evt_desc_err = 1'b0;
    logic          evt_buf_last = 1'b0, evt_buf_ioc = 1'b0;
    logic          out_valid, out_ready = 1'b0, irq;
    logic [DW-1:0] out_data;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    instream_ctl #(.DW(DW), .DEPTH(4)) u_instream_ctl (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic csr_wr(input logic [31:0] d);
        csr_wr_en = 1'b1; csr_wr_data = d;
        tick();
        csr_wr_en = 1'b0;
    endtask

    task automatic push(input logic [3:0] tag, input logic [DW-1:0] d, input bit expect_it);
        smp_valid = 1'b1; smp_tag = tag; smp_data = d;
        if (expect_it) exp_q.push_back(d);
        tick();
        smp_valid = 1'b0;
    endtask

    // monitor: a pop happens on the next edge when valid and ready are both high
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) chk("R3 unexpected sample", {16'h0, out_data}, 32'hxxxx);
            else chk("R3/R4 sample order", {16'h0, out_data}, {16'h0, exp_q.pop_front()});
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick();
        chk("R1 reset value", csr_rd_data, 32'h0004_0000);
        chk("R11 irq at reset", irq, 0);
        chk("R3 empty at reset", out_valid, 0);

        csr_wr(32'hFFFF_FFFF);
        chk("R1/R10 fixed bits, run held by stream reset", csr_rd_data, 32'h00F4_001D);
        csr_wr(32'h0);
        chk("R1 cleared", csr_rd_data, 32'h0004_0000);

        csr_wr(32'h0050_001E);
        chk("R2 control readback", csr_rd_data, 32'h0054_001E);

        out_ready = 1'b1;
        push(4'd5, 16'h0011, 1);
        push(4'd3, 16'h00EE, 0);
        push(4'd5, 16'h0022, 1);
        tick(3);
        chk("R3 matched samples drained", exp_q.size(), 0);
        csr_wr(32'h0050_001C);
        push(4'd5, 16'h0033, 0);
        tick(2);
        chk("R3 no capture with RUN low", out_valid, 0);

        csr_wr(32'h0000_001E);
        push(4'd0, 16'h0044, 0);
        tick(2);
        chk("R3 stream number zero captures nothing", out_valid, 0);

        out_ready = 1'b0;
        csr_wr(32'h0050_001E);
        for (int i = 0; i < 5; i++) push(4'd5, 16'h00A0 + 16'(i), i < 4);
        chk("R4 FIFO error set on overrun", csr_rd_data[27], 1);
        chk("R11 irq from FIFO error", irq, 1);
        out_ready = 1'b1;
        tick(8);
        chk("R4 queued samples delivered, dropped one absent", exp_q.size(), 0);
        chk("R4 FIFO empty after drain", out_valid, 0);

        csr_wr(32'h0050_001E);
        chk("R7 write 0 keeps FIFO error", csr_rd_data[27], 1);
        csr_wr(32'h0850_001E);
        chk("R7 write 1 clears FIFO error", csr_rd_data[27], 0);
        chk("R11 irq drops", irq, 0);

        evt_buf_last = 1'b1; evt_buf_ioc = 1'b0; tick();
        chk("R5 no completion without flag", csr_rd_data[26], 0);
        evt_buf_ioc = 1'b1; tick();
        evt_buf_last = 1'b0; evt_buf_ioc = 1'b0;
        chk("R5 completion set", csr_rd_data[26], 1);
        chk("R11 irq from completion", irq, 1);
        evt_buf_last = 1'b1; evt_buf_ioc = 1'b1;
        csr_wr(32'h0450_001E);
        evt_buf_last = 1'b0; evt_buf_ioc = 1'b0;
        chk("R8 set wins over clear", csr_rd_data[26], 1);
        csr_wr(32'h0450_001E);
        chk("R7 completion cleared", csr_rd_data[26], 0);

        csr_wr(32'h0050_0002);
        evt_buf_last = 1'b1; evt_buf_ioc = 1'b1; tick();
        evt_buf_last = 1'b0; evt_buf_ioc = 1'b0;
        chk("R11 irq masked when enable off", irq, 0);
        chk("R5 status set even when masked", csr_rd_data[26], 1);
        csr_wr(32'h0450_0002);

        evt_desc_loaded = 1'b1; tick(); evt_desc_loaded = 1'b0;
        chk("R9 FIFO ready set", csr_rd_data[29], 1);

        evt_desc_err = 1'b1;
        csr_wr(32'h0050_001E);
        evt_desc_err = 1'b0;
        chk("R6 fetch error stops RUN", csr_rd_data, 32'h3054_001C);
        chk("R11 irq from descriptor error", irq, 1);

        csr_wr(32'h0050_001E);
        out_ready = 1'b0;
        push(4'd5, 16'h0055, 0);
        csr_wr(32'h0050_001F);
        chk("R10 stream reset clears status and RUN", csr_rd_data, 32'h0054_001D);
        tick();
        chk("R10 FIFO emptied", out_valid, 0);
        out_ready = 1'b1;
        csr_wr(32'h0);
        tick(2);
        chk("R1 idle value", csr_rd_data, 32'h0004_0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule